// File: doc/BRIEF.md
# Byte-Serial CRC Generator and Zero-Residue Checker

This block computes a cyclic redundancy check over a stream of bytes, one byte per clock, and serves both ends of a link. The running remainder is kept in a single register. Each accepted byte is folded into the value that the previous byte left behind, so one remainder builds up over the whole frame. The generator polynomial is chosen at run time from three options. Two are 16-bit generators and one is an 8-bit generator.

In generate mode the block accepts the frame's data bytes. After the last one it emits the finished remainder as the bytes to append to the frame, most significant byte first. In check mode the block takes the received frame together with its appended CRC bytes. It reports the frame as intact when the final remainder is zero, so it never has to compare two checksums. Both ends must seed the register with the same start value. The block does this through a start pulse that loads a programmable initial value. No output inversion and no bit reflection is applied, because either one would destroy the zero-residue property.

Top module: `crc_engine`

## Requirements
- R1: While reset is asserted, crcOut reads 0, inReady is 1, and outValid, done and ok are 0.
- R2: A frameStart pulse with no accepted byte loads initVal into the remainder, and crcOut shows it on the next cycle.
- R3: Each byte accepted with inValid and inReady both high is folded in one clock, bit 7 first, starting from the current remainder. crcOut shows the result on the next cycle and holds when no byte and no frameStart arrive.
- R4: polySel selects the generator: 0 is x^8+x^4+x^3+x^2+1 (taps 0x1D, 8-bit), 1 is x^16+x^15+x^2+1 (taps 0x8005), and 2 is x^16+x^12+x^5+1 (taps 0x1021). Over the ASCII bytes "123456789" these give 0x37 from start value 0, 0xFEE8 from start value 0, and 0x29B1 from start value 0xFFFF.
- R5: When frameStart and an accepted byte fall in the same cycle, the byte is folded onto initVal rather than onto the old remainder.
- R6: In generate mode (checkMode=0), accepting the byte with inLast set makes the block present the remainder on outData from the next cycle, high byte first: two bytes for the 16-bit generators and one byte for the 8-bit one. inReady stays 0 until all of these bytes are taken.
- R7: While outValid is 1 and outReady is 0, outValid and outData hold their values.
- R8: done is a one-cycle pulse in the cycle after a byte with inLast set is accepted.
- R9: ok is 1 only in the done cycle of a check-mode frame whose final remainder is zero. In generate mode ok stays 0.
- R10: A frame followed by its appended CRC bytes leaves a zero remainder. Flipping any single bit of that extended frame leaves a nonzero remainder.
- R11: A frameStart pulse while CRC bytes are being emitted drops the rest of the emission, reloads initVal and returns to accepting input on the next cycle.
- R12: With polySel=0 the upper 8 bits of crcOut are 0 after a frameStart, even when initVal has nonzero upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| polySel | input | 2 | Generator select, held stable through a frame |
| initVal | input | 16 | Start value loaded by frameStart |
| checkMode | input | 1 | 1 = check frame, 0 = generate CRC |
| frameStart | input | 1 | Synchronous reload of the remainder |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Marks the final byte of the frame |
| inReady | output | 1 | Block can accept a byte |
| outValid | output | 1 | CRC byte available |
| outData | output | 8 | CRC byte to append |
| outReady | input | 1 | Consumer takes the CRC byte |
| done | output | 1 | Frame finished pulse |
| ok | output | 1 | Zero residue in check mode, valid with done |
| crcOut | output | 16 | Current remainder |

## Verification
Two events can fall in the same clock edge: the reload from frameStart and the folding of a byte. The bench raises frameStart together with the first byte of every frame. The remainder at the end of each frame is judged against a bitwise model that starts from initVal, so any fold onto a stale remainder shows up at once. A second overlap is a reload that arrives while emission is stalled by outReady. It is provoked on purpose, and the bench checks on the following cycle that outValid has dropped, inReady has returned and crcOut equals the new start value.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int N_OUT     = CRC_W / BYTE_W;
  localparam int OUT_IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  localparam logic [1:0] SEL_C8   = 2'd0;
  localparam logic [1:0] SEL_DISK = 2'd1;

  typedef struct packed {
    logic                 seed;
    logic                 fold;
    logic [OUT_IDX_W-1:0] byteIdx;
  } ctrlStrb_t;

  function automatic logic [CRC_W-1:0] polyTaps(input logic [1:0] sel);
    case (sel)
      SEL_C8:   polyTaps = CRC_W'(16'h001D);
      SEL_DISK: polyTaps = CRC_W'(16'h8005);
      default:  polyTaps = CRC_W'(16'h1021);
    endcase
  endfunction
endpackage

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide,
  input  logic [1:0]        polySel,
  input  logic [CRC_W-1:0]  initVal,
  input  logic [BYTE_W-1:0] inData,
  input  ctrlStrb_t         strb,
  output logic [CRC_W-1:0]  crcQ,
  output logic [BYTE_W-1:0] outData,
  output logic              residueZero
);
  logic [CRC_W-1:0] taps;
  logic [CRC_W-1:0] mask;
  logic [CRC_W-1:0] stage [0:BYTE_W];

  assign taps = polyTaps(polySel);
  assign mask = wide ? {CRC_W{1'b1}} : {{(CRC_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  assign stage[0] = (strb.seed ? initVal : crcQ) & mask;

  // unrolled MSB-first shift steps, one per input bit
  for (genvar k = 0; k < BYTE_W; k++) begin : g_step
    logic topBit;
    assign topBit = (wide ? stage[k][CRC_W-1] : stage[k][BYTE_W-1]) ^ inData[BYTE_W-1-k];
    assign stage[k+1] = ((stage[k] << 1) ^ (topBit ? taps : '0)) & mask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          crcQ <= '0;
    else if (strb.fold) crcQ <= stage[BYTE_W];
    else if (strb.seed) crcQ <= stage[0];
  end

  assign outData     = crcQ[strb.byteIdx*BYTE_W +: BYTE_W];
  assign residueZero = (crcQ == '0);
endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wide,
  input  logic      frameStart,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      checkMode,
  input  logic      outReady,
  input  logic      residueZero,
  output ctrlStrb_t strb,
  output logic      inReady,
  output logic      outValid,
  output logic      done,
  output logic      ok
);
  typedef enum logic {ST_TAKE, ST_EMIT} state_e;

  state_e               state;
  logic [OUT_IDX_W-1:0] emitIdx;
  logic [OUT_IDX_W-1:0] lastIdx;
  logic                 accept;
  logic                 chkQ;

  assign inReady  = (state == ST_TAKE);
  assign outValid = (state == ST_EMIT);
  assign accept   = inValid && inReady;
  assign lastIdx  = wide ? OUT_IDX_W'(N_OUT - 1) : '0;

  always_comb begin
    strb.seed    = frameStart;
    strb.fold    = accept;
    strb.byteIdx = lastIdx - emitIdx;
  end

  assign ok = done && chkQ && residueZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_TAKE;
      emitIdx <= '0;
      done    <= 1'b0;
      chkQ    <= 1'b0;
    end else begin
      done <= accept && inLast;
      if (accept && inLast) chkQ <= checkMode;
      if (accept && inLast && !checkMode) begin
        state   <= ST_EMIT;
        emitIdx <= '0;
      end else if (frameStart) begin
        state   <= ST_TAKE;
        emitIdx <= '0;
      end else if (outValid && outReady) begin
        if (emitIdx == lastIdx) state <= ST_TAKE;
        else                    emitIdx <= emitIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        polySel,
  input  logic [CRC_W-1:0]  initVal,
  input  logic              checkMode,
  input  logic              frameStart,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  input  logic              outReady,
  output logic              done,
  output logic              ok,
  output logic [CRC_W-1:0]  crcOut
);
  ctrlStrb_t strb;
  logic      wide;
  logic      residueZero;

  assign wide = (polySel != SEL_C8);

  crc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wide(wide), .frameStart(frameStart),
    .inValid(inValid), .inLast(inLast), .checkMode(checkMode),
    .outReady(outReady), .residueZero(residueZero), .strb(strb),
    .inReady(inReady), .outValid(outValid), .done(done), .ok(ok)
  );

  crc_datapath u_dp (
    .clk(clk), .rstN(rstN), .wide(wide), .polySel(polySel),
    .initVal(initVal), .inData(inData), .strb(strb), .crcQ(crcOut),
    .outData(outData), .residueZero(residueZero)
  );
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  polySel,
  input logic [15:0] initVal,
  input logic        checkMode,
  input logic        frameStart,
  input logic        inValid,
  input logic [7:0]  inData,
  input logic        inLast,
  input logic        inReady,
  input logic        outValid,
  input logic [7:0]  outData,
  input logic        outReady,
  input logic        done,
  input logic        ok,
  input logic [15:0] crcOut
);
  a_r6_no_input_while_emitting: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> done);

  a_r8_done_only_after_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(inValid && inReady && inLast));

  a_r9_ok_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    ok |-> done);

  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !frameStart) |=> (outValid && $stable(outData)));

  a_r3_remainder_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!(inValid && inReady) && !frameStart) |=> $stable(crcOut));

  a_r12_c8_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && polySel == 2'd0) |=> (crcOut[15:8] == 8'h00));

  a_r11_start_aborts_emit: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && frameStart) |=> (inReady && !outValid));
endmodule

bind crc_engine crc_engine_chk u_chk (.*);

// File: tb/tb_crc_engine.sv
`timescale 1ns/1ps
module tb_crc_engine;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  polySel;
  logic [15:0] initVal;
  logic        checkMode, frameStart, inValid, inLast, outReady;
  logic [7:0]  inData;
  logic        inReady, outValid, done, ok;
  logic [7:0]  outData;
  logic [15:0] crcOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] expByteQ[$];
  bit         expOkQ[$];
  logic [7:0] mem [0:31];

  always #2 clk = ~clk;

  crc_engine dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl(input logic [15:0] c, input logic [7:0] d, input logic [1:0] sel);
    logic [15:0] p;
    logic top;
    p = (sel == 2'd0) ? 16'h001D : (sel == 2'd1) ? 16'h8005 : 16'h1021;
    for (int i = 7; i >= 0; i--) begin
      top = ((sel == 2'd0) ? c[7] : c[15]) ^ d[i];
      c = c << 1;
      if (top) c = c ^ p;
      if (sel == 2'd0) c[15:8] = 8'h00;
    end
    return c;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    logic [7:0] eb;
    bit eo;
    if (rstN && !finished) begin
      if (outValid && outReady) begin
        if (expByteQ.size() == 0) begin
          total++; bad++;
          $display("FAIL R6 unexpected byte actual=%h expected=none", outData);
        end else begin
          eb = expByteQ.pop_front();
          chk("R6 appended byte", outData, eb);
        end
      end
      if (done) begin
        if (expOkQ.size() == 0) begin
          total++; bad++;
          $display("FAIL R8 unexpected done actual=1 expected=0");
        end else begin
          eo = expOkQ.pop_front();
          chk("R9 ok flag", ok, eo);
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] d, input bit last, input bit start);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inData = d; inLast = last; frameStart = start; inValid = 1'b1;
    @(posedge clk); #1;
    inValid = 1'b0; inLast = 1'b0; frameStart = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    frameStart = 1'b1;
    @(posedge clk); #1;
    frameStart = 1'b0;
  endtask

  task automatic send_frame(input int n, input bit chkm, input logic [1:0] sel,
                            input logic [15:0] init, input bit pushOut,
                            output logic [15:0] crc);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    polySel = sel; initVal = init; checkMode = chkm;
    crc = (sel == 2'd0) ? {8'h00, init[7:0]} : init;
    for (int i = 0; i < n; i++) crc = mdl(crc, mem[i], sel);
    if (!chkm && pushOut) begin
      if (sel != 2'd0) expByteQ.push_back(crc[15:8]);
      expByteQ.push_back(crc[7:0]);
    end
    expOkQ.push_back(chkm && (crc == 16'h0000));
    for (int i = 0; i < n; i++) send_byte(mem[i], i == n - 1, i == 0);
    @(negedge clk);
    chk("R8 done one cycle after last byte", done, 1);
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((expByteQ.size() != 0 || outValid) && guard < 100) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    logic [7:0]  vec [0:8];
    int n, m, pos;
    logic [1:0] sel;
    rstN = 1'b0; polySel = 2'd2; initVal = 16'h0; checkMode = 1'b0;
    frameStart = 1'b0; inValid = 1'b0; inLast = 1'b0; inData = 8'h0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset crcOut", crcOut, 0);
    chk("R1 reset inReady", inReady, 1);
    chk("R1 reset outValid", outValid, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset ok", ok, 0);
    @(posedge clk); #1 rstN = 1'b1;

    // R12 and R2: reload behaviour
    polySel = 2'd0; initVal = 16'hABCD;
    pulse_start();
    @(negedge clk);
    chk("R12 8-bit reload clears upper", crcOut, 16'h00CD);
    polySel = 2'd2;
    pulse_start();
    @(negedge clk);
    chk("R2 reload loads initVal", crcOut, 16'hABCD);

    // R3/R4 known vectors, frameStart with first byte (R5)
    vec = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    for (int i = 0; i < 9; i++) mem[i] = vec[i];
    send_frame(9, 0, 2'd2, 16'hFFFF, 1, c);
    chk("R3/R4 x16+x12+x5+1 vector", crcOut, 16'h29B1);
    drain();
    send_frame(9, 0, 2'd1, 16'h0000, 1, c);
    chk("R3/R4 x16+x15+x2+1 vector", crcOut, 16'hFEE8);
    drain();
    send_frame(9, 0, 2'd0, 16'h0000, 1, c);
    chk("R3/R4 8-bit vector", crcOut, 16'h0037);
    drain();

    // R10 on the known vector
    for (int i = 0; i < 9; i++) mem[i] = vec[i];
    mem[9] = 8'h29; mem[10] = 8'hB1;
    send_frame(11, 1, 2'd2, 16'hFFFF, 1, c);
    chk("R10 zero residue on vector", crcOut, 0);

    // R5: single byte with start, remainder nonzero beforehand
    mem[0] = 8'hA5;
    send_frame(1, 0, 2'd1, 16'h1357, 1, c);
    chk("R5 byte folded onto initVal", crcOut, mdl(16'h1357, 8'hA5, 2'd1));
    drain();

    // R7: stalled emission holds
    @(posedge clk); #1 outReady = 1'b0;
    mem[0] = 8'h5A; mem[1] = 8'hC3;
    send_frame(2, 0, 2'd1, 16'hFFFF, 1, c);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 outValid held", outValid, 1);
      chk("R7 outData held", outData, c[15:8]);
      chk("R6 inReady low while emitting", inReady, 0);
    end
    @(posedge clk); #1 outReady = 1'b1;
    drain();

    // R11: reload during emission
    @(posedge clk); #1 outReady = 1'b0;
    send_frame(2, 0, 2'd2, 16'h0F0F, 0, c);
    chk("R11 emitting before reload", outValid, 1);
    initVal = 16'h1234;
    pulse_start();
    @(negedge clk);
    chk("R11 emission dropped", outValid, 0);
    chk("R11 input accepted again", inReady, 1);
    chk("R11 reloaded", crcOut, 16'h1234);
    @(posedge clk); #1 outReady = 1'b1;

    // random frames: generate, check, corrupt (R3 R6 R9 R10)
    for (int f = 0; f < 24; f++) begin
      n = 1 + ($urandom % 10);
      sel = 2'($urandom % 3);
      for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
      send_frame(n, 0, sel, 16'($urandom), 1, c);
      chk("R3 remainder matches model", crcOut, c);
      drain();
      m = n;
      if (sel != 2'd0) begin mem[m] = c[15:8]; m++; end
      mem[m] = c[7:0]; m++;
      send_frame(m, 1, sel, initVal, 1, c);
      chk("R10 appended CRC gives zero", crcOut, 0);
      pos = $urandom % (m * 8);
      mem[pos / 8] = mem[pos / 8] ^ (8'h01 << (pos % 8));
      send_frame(m, 1, sel, initVal, 1, c);
      chk("R10 single flip gives nonzero", (crcOut != 16'h0), 1);
    end

    repeat (10) @(negedge clk);
    chk("R6 scoreboard drained", expByteQ.size() + expOkQ.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule